// File: doc/BRIEF.md
# Indexed Super I/O Configuration Decoder

This block holds the configuration state for a legacy PC peripheral controller. Software reaches it through a pair of byte ports on an 8-bit host I/O bus. It uses that state to turn the 10-bit I/O address into chip-select strobes for two serial ports, one parallel port, a floppy controller and an IDE interface. The serial, parallel, floppy and IDE functions themselves are outside the block. Only their select strobes are produced here.

Host software first writes an index to the even port of the pair, then reads or writes the odd port to reach the selected configuration byte. Indices below the configuration range have no storage and read back as all ones. Each select is combinational. It is built from the registered configuration, the live address and the read/write strobes, so a configuration write changes decoding from the next clock edge onward.

The bus is a synchronous single-cycle strobe interface with no wait states. A strobe is high for one clock, and a write is captured at that clock's rising edge.

Top module: `sio_cfg_decoder`

## Requirements
- R1: A write with `busAddr` equal to `CFG_BASE` (default 0x0F2) loads `wrData` into the index. A read at that address returns the current index on `rdData` in the same cycle.
- R2: A write at `CFG_BASE+1` stores `wrData` into the byte selected by the index when the index is 0xBC or above. A read at `CFG_BASE+1` returns that byte.
- R3: A read at `CFG_BASE+1` returns 0xFF while the index is below 0xBC, and writes at such indices change nothing. `rdData` is 0x00 in any cycle without a read of the port pair.
- R4: After reset the index is 0x00, byte 0xBF is 0xDE, byte 0xDC is 0xFE, byte 0xDD is 0xBE, and every other byte is 0x00.
- R5: `parCs` covers 4 bytes starting at (byte 0xBF) << 2, comparing A9..A2 to byte 0xBF.
- R6: `serCsA` covers the 8 bytes whose A9..A3 equal bits 7..1 of byte 0xDC. `serCsB` does the same with byte 0xDD.
- R7: While bit 0 of byte 0xDC is 1, the parallel decode ignores A2, so it compares A9..A3 only and the window grows to 8 bytes.
- R8: In byte 0xDB, bit 4 (disable) or bit 3 (power-down) blocks `serCsA`, and bit 1 or bit 0 blocks `serCsB`. Bit 2 has no effect on decoding.
- R9: In byte 0xBE, bit 4 (disable) or bit 3 (power-down) blocks `parCs`.
- R10: `fdcCs` covers 0x3F0..0x3F7 when bit 0 of byte 0xFB is 0, and 0x370..0x377 when it is 1. Bit 1 of byte 0xFB blocks it.
- R11: `ideCs` covers 0x1F0..0x1F7. Bit 1 of byte 0xFE blocks it.
- R12: No chip select is high unless `rdEn` or `wrEn` is high. A configuration write affects the selects from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Host I/O address A9..A0 |
| rdEn | input | 1 | Read strobe, one cycle |
| wrEn | input | 1 | Write strobe, one cycle |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Configuration read data |
| serCsA | output | 1 | Primary serial port select |
| serCsB | output | 1 | Secondary serial port select |
| parCs | output | 1 | Parallel port select |
| fdcCs | output | 1 | Floppy controller select |
| ideCs | output | 1 | IDE interface select |

## Verification
Each configuration state is followed by a sweep of addresses that sit on the first and last byte of every window and one byte past the edges. This separates a 4-byte decode from an 8-byte decode, and catches off-by-one compares on A2 and A3. The disable and power-down bits are set one at a time, and the reserved bit is set alone, so a swapped or merged control bit blocks the wrong select. The sweep repeats with strobes low and with a write strobe instead of a read. Index reads and writes below, at and above 0xBC show whether the hidden range is masked while the stored range stays reachable.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;

  // Index values that software uses to reach the configuration bytes
  localparam logic [7:0] IDX_LOW       = 8'hBC;
  localparam logic [7:0] IDX_PAR_CTL   = 8'hBE;
  localparam logic [7:0] IDX_PAR_BASE  = 8'hBF;
  localparam logic [7:0] IDX_SER_CTL   = 8'hDB;
  localparam logic [7:0] IDX_SERA_BASE = 8'hDC;
  localparam logic [7:0] IDX_SERB_BASE = 8'hDD;
  localparam logic [7:0] IDX_FDC_CTL   = 8'hFB;
  localparam logic [7:0] IDX_IDE_CTL   = 8'hFE;

  // Strobes from the port-pair control to the register datapath
  typedef struct packed {
    logic idxLoad;
    logic dataStore;
    logic idxRead;
    logic dataRead;
  } cfgStrobe_t;

  // Configuration bytes consumed by the address decoder
  typedef struct packed {
    logic [BYTE_W-1:0] parCtl;
    logic [BYTE_W-1:0] parBase;
    logic [BYTE_W-1:0] serCtl;
    logic [BYTE_W-1:0] serABase;
    logic [BYTE_W-1:0] serBBase;
    logic [BYTE_W-1:0] fdcCtl;
    logic [BYTE_W-1:0] ideCtl;
  } cfgView_t;

  function automatic logic [BYTE_W-1:0] resetValue(input logic [7:0] idx);
    case (idx)
      IDX_PAR_BASE:  return 8'hDE;
      IDX_SERA_BASE: return 8'hFE;
      IDX_SERB_BASE: return 8'hBE;
      default:       return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_BASE = 10'h0F2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  output cfgStrobe_t        strobe
);

  logic pairHit;
  logic oddPort;

  assign pairHit = (busAddr[ADDR_W-1:1] == CFG_BASE[ADDR_W-1:1]);
  assign oddPort = busAddr[0];

  always_comb begin
    strobe.idxLoad   = pairHit && !oddPort && wrEn;
    strobe.dataStore = pairHit &&  oddPort && wrEn;
    strobe.idxRead   = pairHit && !oddPort && rdEn;
    strobe.dataRead  = pairHit &&  oddPort && rdEn;
  end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] LOW_IDX = IDX_LOW
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic [7:0]        curIdx,
  output cfgView_t          view
);

  localparam int NUM_SLOTS = 256 - int'(LOW_IDX);

  logic [BYTE_W-1:0] slot [NUM_SLOTS];
  logic [7:0]        slotSel;

  always_ff @(posedge clk) begin
    if (!rstN)               curIdx <= '0;
    else if (strobe.idxLoad) curIdx <= wrData;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    localparam logic [7:0] MY_IDX = 8'(int'(LOW_IDX) + i);
    always_ff @(posedge clk) begin
      if (!rstN)
        slot[i] <= resetValue(MY_IDX);
      else if (strobe.dataStore && curIdx == MY_IDX)
        slot[i] <= wrData;
    end
  end

  assign slotSel = curIdx - LOW_IDX;

  always_comb begin
    rdData = '0;
    if (strobe.idxRead)
      rdData = curIdx;
    else if (strobe.dataRead)
      rdData = (curIdx < LOW_IDX) ? '1 : slot[slotSel];
  end

  always_comb begin
    view.parCtl   = slot[IDX_PAR_CTL   - LOW_IDX];
    view.parBase  = slot[IDX_PAR_BASE  - LOW_IDX];
    view.serCtl   = slot[IDX_SER_CTL   - LOW_IDX];
    view.serABase = slot[IDX_SERA_BASE - LOW_IDX];
    view.serBBase = slot[IDX_SERB_BASE - LOW_IDX];
    view.fdcCtl   = slot[IDX_FDC_CTL   - LOW_IDX];
    view.ideCtl   = slot[IDX_IDE_CTL   - LOW_IDX];
  end

endmodule

// File: rtl/sio_port_decode.sv
module sio_port_decode
  import sio_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FDC_PRI = 10'h3F0,
  parameter logic [ADDR_W-1:0] FDC_SEC = 10'h370,
  parameter logic [ADDR_W-1:0] IDE_PRI = 10'h1F0
) (
  input  cfgView_t          view,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busActive,
  output logic [1:0]        serCs,
  output logic              parCs,
  output logic              fdcCs,
  output logic              ideCs
);

  localparam int SER_PORTS = 2;

  logic [BYTE_W-1:0] serBase [SER_PORTS];
  logic [SER_PORTS-1:0] serOff;
  logic [ADDR_W-1:0] fdcBase;
  logic parWide;
  logic parHit;

  assign serBase[0] = view.serABase;
  assign serBase[1] = view.serBBase;
  // primary port: disable bit 4, power-down bit 3; secondary: bits 1 and 0
  assign serOff[0]  = view.serCtl[4] | view.serCtl[3];
  assign serOff[1]  = view.serCtl[1] | view.serCtl[0];

  for (genvar p = 0; p < SER_PORTS; p++) begin : gSer
    assign serCs[p] = busActive && !serOff[p] &&
                      (busAddr[ADDR_W-1:3] == serBase[p][BYTE_W-1:1]);
  end

  assign parWide = view.serABase[0];
  assign parHit  = parWide ? (busAddr[ADDR_W-1:3] == view.parBase[BYTE_W-1:1])
                           : (busAddr[ADDR_W-1:2] == view.parBase);
  assign parCs   = busActive && parHit && !(view.parCtl[4] | view.parCtl[3]);

  assign fdcBase = view.fdcCtl[0] ? FDC_SEC : FDC_PRI;
  assign fdcCs   = busActive && !view.fdcCtl[1] &&
                   (busAddr[ADDR_W-1:3] == fdcBase[ADDR_W-1:3]);

  assign ideCs   = busActive && !view.ideCtl[1] &&
                   (busAddr[ADDR_W-1:3] == IDE_PRI[ADDR_W-1:3]);

endmodule

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder
  import sio_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_BASE = 10'h0F2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              serCsA,
  output logic              serCsB,
  output logic              parCs,
  output logic              fdcCs,
  output logic              ideCs
);

  cfgStrobe_t strobe;
  cfgView_t   view;
  logic [7:0] curIdx;
  logic [1:0] serCs;

  sio_cfg_ctrl #(.CFG_BASE(CFG_BASE)) ctrl_i (
    .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn), .strobe(strobe)
  );

  sio_cfg_regs regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .curIdx(curIdx), .view(view)
  );

  sio_port_decode dec_i (
    .view(view), .busAddr(busAddr), .busActive(rdEn | wrEn),
    .serCs(serCs), .parCs(parCs), .fdcCs(fdcCs), .ideCs(ideCs)
  );

  assign serCsA = serCs[0];
  assign serCsB = serCs[1];

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker
  import sio_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_BASE = 10'h0F2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              rdEn,
  input logic              wrEn,
  input logic [BYTE_W-1:0] wrData,
  input logic [BYTE_W-1:0] rdData,
  input logic              serCsA,
  input logic              serCsB,
  input logic              parCs,
  input logic              fdcCs,
  input logic              ideCs,
  input logic [7:0]        curIdx
);

  localparam logic [ADDR_W-1:0] DATA_PORT = CFG_BASE + 10'd1;

  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == CFG_BASE) |=> (curIdx == $past(wrData)));

  assert_index_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busAddr == CFG_BASE) |-> (rdData == curIdx));

  assert_hidden_ff_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busAddr == DATA_PORT && curIdx < IDX_LOW) |-> (rdData == 8'hFF));

  assert_cs_needs_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    (serCsA || serCsB || parCs || fdcCs || ideCs) |-> (rdEn || wrEn));

  assert_ser_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr == DATA_PORT && curIdx == IDX_SER_CTL && (wrData[4] || wrData[3]))
    |=> !serCsA);

  assert_ide_window_R11: assert property (@(posedge clk) disable iff (!rstN)
    ideCs |-> (busAddr[ADDR_W-1:3] == 7'h3E));

endmodule

bind sio_cfg_decoder sio_cfg_checker #(.CFG_BASE(CFG_BASE)) chk_i (.*);

// File: tb/sio_cfg_decoder_tb.sv
`timescale 1ns/1ps
module sio_cfg_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] busAddr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       serCsA, serCsB, parCs, fdcCs, ideCs;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int mreg [256];
  int midx;

  always #2.5 clk = ~clk;

  sio_cfg_decoder dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .serCsA(serCsA), .serCsB(serCsB),
    .parCs(parCs), .fdcCs(fdcCs), .ideCs(ideCs)
  );

  task automatic modelReset();
    for (int i = 0; i < 256; i++) mreg[i] = 0;
    mreg['hBF] = 'hDE;
    mreg['hDC] = 'hFE;
    mreg['hDD] = 'hBE;
    midx = 0;
  endtask

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(input string tag, input int a, input bit r, input bit w);
    bit act = r | w;
    int expRd, fb;
    bit eA, eB, eP, eF, eI;
    eA = act && ((a >> 3) == (mreg['hDC] >> 1)) && ((mreg['hDB] & 'h18) == 0);
    eB = act && ((a >> 3) == (mreg['hDD] >> 1)) && ((mreg['hDB] & 'h03) == 0);
    if (mreg['hDC] & 1) eP = ((a >> 3) == (mreg['hBF] >> 1));
    else                eP = ((a >> 2) == mreg['hBF]);
    eP = eP && act && ((mreg['hBE] & 'h18) == 0);
    fb = (mreg['hFB] & 1) ? 'h370 : 'h3F0;
    eF = act && ((a >> 3) == (fb >> 3)) && ((mreg['hFB] & 2) == 0);
    eI = act && ((a >> 3) == ('h1F0 >> 3)) && ((mreg['hFE] & 2) == 0);
    expRd = 0;
    if (r && a == 'h0F2) expRd = midx;
    else if (r && a == 'h0F3) expRd = (midx < 'hBC) ? 'hFF : mreg[midx];
    check(tag, "rdData", int'(rdData), expRd);
    check(tag, "serCsA", int'(serCsA), int'(eA));
    check(tag, "serCsB", int'(serCsB), int'(eB));
    check(tag, "parCs",  int'(parCs),  int'(eP));
    check(tag, "fdcCs",  int'(fdcCs),  int'(eF));
    check(tag, "ideCs",  int'(ideCs),  int'(eI));
  endtask

  task automatic cyc(input int a, input bit r, input bit w, input int d, input string tag);
    @(negedge clk);
    busAddr = 10'(a); rdEn = r; wrEn = w; wrData = 8'(d);
    #1;
    compareAll(tag, a, r, w);
    @(posedge clk);
    if (w && a == 'h0F2) midx = d;
    else if (w && a == 'h0F3 && midx >= 'hBC) mreg[midx] = d;
  endtask

  task automatic setReg(input int idx, input int val, input string tag);
    cyc('h0F2, 0, 1, idx, tag);
    cyc('h0F3, 0, 1, val, tag);
    cyc('h0F3, 1, 0, 0, tag);
  endtask

  task automatic scan(input string tag);
    int addrs [22] = '{'h378, 'h37B, 'h37C, 'h37F, 'h377, 'h278, 'h27B, 'h27C,
                       'h3F8, 'h3FF, 'h2F8, 'h2FF, 'h3E8, 'h138, 'h13F,
                       'h3F0, 'h3F7, 'h370, 'h377, 'h1F0, 'h1F7, 'h1EF};
    foreach (addrs[i]) cyc(addrs[i], 1, 0, 0, tag);
    foreach (addrs[i]) cyc(addrs[i], 0, 1, 0, tag);
    // R12: no strobe, no select
    cyc('h3F8, 0, 0, 0, tag);
    cyc('h378, 0, 0, 0, tag);
    cyc('h1F0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R4: reset state through reads and the default windows
    cyc('h0F2, 1, 0, 0, "R4");
    cyc('h0F3, 1, 0, 0, "R3");
    scan("R4");
    cyc('h0F2, 0, 1, 'hBF, "R4");
    cyc('h0F3, 1, 0, 0, "R4");
    cyc('h0F2, 0, 1, 'hDC, "R4");
    cyc('h0F3, 1, 0, 0, "R4");
    cyc('h0F2, 0, 1, 'hDD, "R4");
    cyc('h0F3, 1, 0, 0, "R4");
    // R1: index load and readback
    cyc('h0F2, 0, 1, 'h5A, "R1");
    cyc('h0F2, 1, 0, 0, "R1");
    cyc('h0F2, 0, 1, 'hFF, "R1");
    cyc('h0F2, 1, 0, 0, "R1");
    // R3: hidden range reads all ones, writes there have no visible effect
    cyc('h0F2, 0, 1, 'hBB, "R3");
    cyc('h0F3, 0, 1, 'h12, "R3");
    cyc('h0F3, 1, 0, 0, "R3");
    cyc('h0F2, 0, 1, 'h00, "R3");
    cyc('h0F3, 1, 0, 0, "R3");
    scan("R3");
    // R2: storage at the low edge and an unused byte
    setReg('hBC, 'hA5, "R2");
    setReg('hF0, 'h3C, "R2");
    setReg('hFF, 'h81, "R2");
    // R5: move parallel window
    setReg('hBF, 'h9E, "R5");
    scan("R5");
    // R7: A2 ignored by the parallel decode
    setReg('hDC, 'hFF, "R7");
    scan("R7");
    setReg('hBF, 'hDE, "R7");
    scan("R7");
    // R6: move both serial windows
    setReg('hDC, 'hFA, "R6");
    setReg('hDD, 'h4E, "R6");
    scan("R6");
    setReg('hDC, 'hFE, "R6");
    setReg('hDD, 'hBE, "R6");
    // R8: each serial control bit alone, then the reserved bit
    setReg('hDB, 'h10, "R8"); scan("R8");
    setReg('hDB, 'h08, "R8"); scan("R8");
    setReg('hDB, 'h02, "R8"); scan("R8");
    setReg('hDB, 'h01, "R8"); scan("R8");
    setReg('hDB, 'h04, "R8"); scan("R8");
    setReg('hDB, 'h00, "R8");
    // R9: parallel control bits
    setReg('hBE, 'h10, "R9"); scan("R9");
    setReg('hBE, 'h08, "R9"); scan("R9");
    setReg('hBE, 'h00, "R9");
    // R10: floppy base select and disable
    setReg('hFB, 'h01, "R10"); scan("R10");
    setReg('hFB, 'h03, "R10"); scan("R10");
    setReg('hFB, 'h02, "R10"); scan("R10");
    // R11: IDE disable
    setReg('hFE, 'h02, "R11"); scan("R11");
    setReg('hFE, 'h00, "R11"); scan("R11");
    // R12: write then immediate decode in the following cycle
    cyc('h0F2, 0, 1, 'hDB, "R12");
    cyc('h0F3, 0, 1, 'h18, "R12");
    cyc('h3F8, 1, 0, 0, "R12");
    cyc('h0F3, 0, 1, 'h00, "R12");
    cyc('h3F8, 1, 0, 0, "R12");
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule